// File: doc/BRIEF.md
# Serial Configuration Port with Calibration Timer

This block is the control front of an analog front end. A host writes it over a three-wire serial link (an active-low select, a clock and a data line). Each transfer carries one 16-bit word, sent least significant bit first. The block holds the received settings in four small configuration registers and drives every decoded field straight out as a plain control pin. The settings cover gain, black clamp level, the fast-settling loop selects, power modes, signal polarity, output code format and a run bit.

All three serial lines are brought into the conversion clock domain through two-flop synchronizers. A word only takes effect when the select line rises after exactly sixteen serial clock edges. A shorter or longer transfer is discarded. Releasing the run bit, that is writing it from 0 to 1, starts a calibration window of fixed length in conversion clocks. A busy flag stays high for the whole window. A one-cycle strobe reports each committed change of the gain value.

The block has no data stream and so no valid/ready pair. Every output is a level that is held until the next committed write.

Top module: `afe_ctrl_port`

## Requirements
- R1: After reset every configuration output is 0, and cal_busy and gain_stb are 0.
- R2: Serial data is sampled on rising ser_sck edges while ser_csn is low. The first bit sampled becomes word bit 0 and the sixteenth becomes bit 15. Bits 2:0 of the word are the register address and bits 15:3 are the payload (payload bit k is word bit k+3).
- R3: A word is committed only when ser_csn rises after exactly 16 rising ser_sck edges. A transfer with 15 or 17 edges leaves every output unchanged.
- R4: Address 0 writes gain from payload bits 9:0.
- R5: Address 1 writes clamp from payload bits 4:0, lead_gain from bits 6:5 and lead_hold from bits 8:7.
- R6: Address 2 writes run_mode, standby, sleep, low_power, samp_inv and ob_inv from payload bits 0, 1, 2, 3, 4 and 5.
- R7: Address 3 writes inv_lsbs, inv_msb, test0 and test1 from payload bits 0, 1, 2 and 3.
- R8: Writes to addresses 4 to 7 change no output.
- R9: gain_stb is high for exactly one clock when a committed address-0 write changes gain. A write of the same gain value gives no pulse.
- R10: cal_busy rises one clock after run_mode goes from 0 to 1. It then stays high for exactly CAL_CYCLES clocks, which defaults to 40000.
- R11: Writing run_mode to 0 clears cal_busy on the next clock. Writing run_mode as 1 while it is already 1 does not restart the window.
- R12: Activity on ser_sck while ser_csn is high changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_csn | input | 1 | Serial select, active low |
| ser_sck | input | 1 | Serial clock |
| ser_sdi | input | 1 | Serial data, LSB first |
| gain | output | 10 | Amplifier gain code |
| clamp | output | 5 | Black clamp level code |
| lead_gain | output | 2 | Fast-settling loop gain multiplier select |
| lead_hold | output | 2 | Fast-settling release time select |
| run_mode | output | 1 | 0 = held in reset mode, 1 = running |
| standby | output | 1 | Standby request |
| sleep | output | 1 | Sleep request |
| low_power | output | 1 | Low-power mode |
| samp_inv | output | 1 | Sampling pulse polarity invert |
| ob_inv | output | 1 | Black-reference pulse polarity invert |
| inv_lsbs | output | 1 | Invert lower output code bits |
| inv_msb | output | 1 | Invert top output code bit |
| test0 | output | 1 | Output test mode bit 0 |
| test1 | output | 1 | Output test mode bit 1 |
| gain_stb | output | 1 | One-clock pulse on a gain change |
| cal_busy | output | 1 | Calibration window active |

## Verification
A wrong bit counter or shift alignment shows up at the first committed word. The field lands at the wrong position, or a word that should commit is dropped. The bench sees this about ten clocks after the select line rises. A fault in the timer shows up in the length of the busy window. A window that restarts on a repeated run write shows as a count far above CAL_CYCLES. A lost abort leaves cal_busy high one clock after run_mode falls, and a duplicate or missing gain strobe is counted around each write.

// File: rtl/afe_ctrl_pkg.sv
package afe_ctrl_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 3;
  localparam int PAY_W   = FRAME_W - ADDR_W;
  localparam int GAIN_W  = 10;
  localparam int CLAMP_W = 5;
  localparam int LEAD_W  = 2;

  localparam logic [ADDR_W-1:0] A_GAIN   = 3'd0;
  localparam logic [ADDR_W-1:0] A_BLACK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_POWER  = 3'd2;
  localparam logic [ADDR_W-1:0] A_OUTFMT = 3'd3;

  typedef struct packed {
    logic [GAIN_W-1:0]  gain;
    logic [CLAMP_W-1:0] clamp;
    logic [LEAD_W-1:0]  lead_gain;
    logic [LEAD_W-1:0]  lead_hold;
    logic run;
    logic standby;
    logic sleep;
    logic low_power;
    logic samp_inv;
    logic ob_inv;
    logic inv_lsbs;
    logic inv_msb;
    logic test0;
    logic test1;
  } cfg_t;
endpackage

// File: rtl/afe_sif_rx.sv
module afe_sif_rx #(
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csn,
  input  logic               sck,
  input  logic               sdi,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] csn_sy, sck_sy, sdi_sy;
  logic csn_q, sck_q;
  logic csn_now, sck_now, sdi_now;
  logic sck_rise, cs_rise;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   nbits;

  // two-flop (or deeper) synchronizers into the conversion clock domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_sy <= '1;
      sck_sy <= '0;
      sdi_sy <= '0;
    end else begin
      csn_sy <= {csn_sy[SYNC_STAGES-2:0], csn};
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck};
      sdi_sy <= {sdi_sy[SYNC_STAGES-2:0], sdi};
    end
  end

  assign csn_now  = csn_sy[SYNC_STAGES-1];
  assign sck_now  = sck_sy[SYNC_STAGES-1];
  assign sdi_now  = sdi_sy[SYNC_STAGES-1];
  assign sck_rise = sck_now & ~sck_q;
  assign cs_rise  = csn_now & ~csn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q      <= 1'b1;
      sck_q      <= 1'b0;
      shreg      <= '0;
      nbits      <= '0;
      frame_vld  <= 1'b0;
      frame_word <= '0;
    end else begin
      csn_q     <= csn_now;
      sck_q     <= sck_now;
      frame_vld <= cs_rise && (nbits == CNT_FULL);
      if (cs_rise) frame_word <= shreg;
      if (csn_now) begin
        nbits <= '0;
      end else if (sck_rise) begin
        shreg <= {sdi_now, shreg[FRAME_W-1:1]};
        if (nbits != CNT_OVER) nbits <= nbits + 1'b1;
      end
    end
  end
endmodule

// File: rtl/afe_cfg_regs.sv
module afe_cfg_regs
  import afe_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_vld,
  input  logic [FRAME_W-1:0] frame_word,
  output cfg_t               cfg,
  output logic               gain_stb
);
  logic [ADDR_W-1:0] addr;
  logic [PAY_W-1:0]  pay;
  cfg_t              cfg_nxt;
  logic              unused_pay;

  assign addr       = frame_word[ADDR_W-1:0];
  assign pay        = frame_word[FRAME_W-1:ADDR_W];
  assign unused_pay = ^pay[PAY_W-1:GAIN_W];

  always_comb begin
    cfg_nxt = cfg;
    if (frame_vld) begin
      case (addr)
        A_GAIN:  cfg_nxt.gain = pay[GAIN_W-1:0];
        A_BLACK: begin
          cfg_nxt.clamp     = pay[CLAMP_W-1:0];
          cfg_nxt.lead_gain = pay[CLAMP_W+LEAD_W-1:CLAMP_W];
          cfg_nxt.lead_hold = pay[CLAMP_W+2*LEAD_W-1:CLAMP_W+LEAD_W];
        end
        A_POWER: begin
          cfg_nxt.run       = pay[0];
          cfg_nxt.standby   = pay[1];
          cfg_nxt.sleep     = pay[2];
          cfg_nxt.low_power = pay[3];
          cfg_nxt.samp_inv  = pay[4];
          cfg_nxt.ob_inv    = pay[5];
        end
        A_OUTFMT: begin
          cfg_nxt.inv_lsbs = pay[0];
          cfg_nxt.inv_msb  = pay[1];
          cfg_nxt.test0    = pay[2];
          cfg_nxt.test1    = pay[3];
        end
        default: ; // test-only addresses: no user setting moves
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      gain_stb <= 1'b0;
    end else begin
      cfg      <= cfg_nxt;
      gain_stb <= (cfg_nxt.gain != cfg.gain);
    end
  end
endmodule

// File: rtl/afe_cal_timer.sv
module afe_cal_timer #(
  parameter int CAL_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic busy
);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CAL_CYCLES - 1);

  logic          run_q;
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      busy  <= 1'b0;
      left  <= '0;
    end else begin
      run_q <= run;
      if (!run) begin
        busy <= 1'b0;
        left <= '0;
      end else if (!run_q) begin
        busy <= 1'b1;
        left <= LOAD;
      end else if (busy) begin
        if (left == '0) busy <= 1'b0;
        else            left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/afe_ctrl_port.sv
module afe_ctrl_port
  import afe_ctrl_pkg::*;
#(
  parameter int CAL_CYCLES  = 40000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_csn,
  input  logic               ser_sck,
  input  logic               ser_sdi,
  output logic [GAIN_W-1:0]  gain,
  output logic [CLAMP_W-1:0] clamp,
  output logic [LEAD_W-1:0]  lead_gain,
  output logic [LEAD_W-1:0]  lead_hold,
  output logic               run_mode,
  output logic               standby,
  output logic               sleep,
  output logic               low_power,
  output logic               samp_inv,
  output logic               ob_inv,
  output logic               inv_lsbs,
  output logic               inv_msb,
  output logic               test0,
  output logic               test1,
  output logic               gain_stb,
  output logic               cal_busy
);
  logic               frame_vld;
  logic [FRAME_W-1:0] frame_word;
  cfg_t               cfg;

  afe_sif_rx #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .csn(ser_csn), .sck(ser_sck), .sdi(ser_sdi),
    .frame_vld(frame_vld), .frame_word(frame_word)
  );

  afe_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_word(frame_word),
    .cfg(cfg), .gain_stb(gain_stb)
  );

  afe_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk(clk), .rst_n(rst_n), .run(cfg.run), .busy(cal_busy)
  );

  assign gain      = cfg.gain;
  assign clamp     = cfg.clamp;
  assign lead_gain = cfg.lead_gain;
  assign lead_hold = cfg.lead_hold;
  assign run_mode  = cfg.run;
  assign standby   = cfg.standby;
  assign sleep     = cfg.sleep;
  assign low_power = cfg.low_power;
  assign samp_inv  = cfg.samp_inv;
  assign ob_inv    = cfg.ob_inv;
  assign inv_lsbs  = cfg.inv_lsbs;
  assign inv_msb   = cfg.inv_msb;
  assign test0     = cfg.test0;
  assign test1     = cfg.test1;
endmodule

// File: rtl/afe_ctrl_port_chk.sv
module afe_ctrl_port_chk #(
  parameter int CAL_CYCLES = 40000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] gain,
  input logic       gain_stb,
  input logic       run_mode,
  input logic       cal_busy
);
  int unsigned hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_len <= 0;
    else if (cal_busy) hi_len <= hi_len + 1;
    else               hi_len <= 0;
  end

  // R9: a strobe always accompanies a new gain value
  a_r9_stb_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    gain_stb |-> gain != $past(gain));
  // R9: gain never moves without a strobe
  a_r9_gain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_stb |-> $stable(gain));
  // R10: busy only rises one clock after run_mode rose
  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy) |-> run_mode && $past(run_mode) && !$past(run_mode, 2));
  // R10: the window never runs past its length
  a_r10_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> hi_len < CAL_CYCLES);
  // R10: an unaborted window lasts exactly CAL_CYCLES clocks
  a_r10_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) && run_mode |-> hi_len == CAL_CYCLES);
  // R11: busy implies the run bit is set
  a_r11_busy_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy && !$rose(cal_busy) |-> $past(run_mode));
endmodule

bind afe_ctrl_port afe_ctrl_port_chk #(.CAL_CYCLES(CAL_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .gain(gain), .gain_stb(gain_stb),
  .run_mode(run_mode), .cal_busy(cal_busy)
);

// File: tb/afe_ctrl_port_bench.sv
module afe_ctrl_port_bench;
  localparam int HALF  = 8;
  localparam int CAL_N = 40000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_csn = 1'b1, ser_sck = 1'b0, ser_sdi = 1'b0;
  logic [9:0] gain;
  logic [4:0] clamp;
  logic [1:0] lead_gain, lead_hold;
  logic run_mode, standby, sleep, low_power, samp_inv, ob_inv;
  logic inv_lsbs, inv_msb, test0, test1, gain_stb, cal_busy;

  int n_tests = 0, n_fail = 0;
  int stb_cnt = 0, busy_cnt = 0;
  logic [28:0] exp_v = '0;
  logic [28:0] obs;

  always #4 clk = ~clk;

  afe_ctrl_port u_afe_ctrl_port (
    .clk(clk), .rst_n(rst_n), .ser_csn(ser_csn), .ser_sck(ser_sck), .ser_sdi(ser_sdi),
    .gain(gain), .clamp(clamp), .lead_gain(lead_gain), .lead_hold(lead_hold),
    .run_mode(run_mode), .standby(standby), .sleep(sleep), .low_power(low_power),
    .samp_inv(samp_inv), .ob_inv(ob_inv), .inv_lsbs(inv_lsbs), .inv_msb(inv_msb),
    .test0(test0), .test1(test1), .gain_stb(gain_stb), .cal_busy(cal_busy)
  );

  assign obs = {gain, clamp, lead_gain, lead_hold, run_mode, standby, sleep,
                low_power, samp_inv, ob_inv, inv_lsbs, inv_msb, test0, test1};

  always @(negedge clk) begin
    if (gain_stb) stb_cnt <= stb_cnt + 1;
    if (cal_busy) busy_cnt <= busy_cnt + 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] want);
    n_tests++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, want);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nclk);
    @(negedge clk) ser_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      ser_sdi = (i < 16) ? w[i] : 1'b0;
      repeat (HALF) @(negedge clk);
      ser_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      ser_sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    ser_csn = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // model of the register decode, from R4..R8
  function automatic logic [28:0] model(input logic [28:0] e, input logic [2:0] a, input logic [12:0] p);
    logic [28:0] r = e;
    case (a)
      3'd0: r[28:19] = p[9:0];
      3'd1: begin r[18:14] = p[4:0]; r[13:12] = p[6:5]; r[11:10] = p[8:7]; end
      3'd2: begin r[9] = p[0]; r[8] = p[1]; r[7] = p[2]; r[6] = p[3]; r[5] = p[4]; r[4] = p[5]; end
      3'd3: begin r[3] = p[0]; r[2] = p[1]; r[1] = p[2]; r[0] = p[3]; end
      default: ;
    endcase
    return r;
  endfunction

  task automatic wr(input string req, input logic [2:0] a, input logic [12:0] p);
    int s0;
    logic [9:0] g0;
    s0 = stb_cnt;
    g0 = exp_v[28:19];
    send({p, a}, 16);
    exp_v = model(exp_v, a, p);
    chk(req, "fields after write", 32'(obs), 32'(exp_v));
    chk("R9", "gain strobe count", 32'(stb_cnt - s0), (a == 3'd0 && p[9:0] != g0) ? 32'd1 : 32'd0);
  endtask

  initial begin
    repeat (CAL_N + 150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "outputs after reset", 32'(obs), 32'd0);
    chk("R1", "busy/strobe after reset", {30'd0, cal_busy, gain_stb}, 32'd0);

    // R4, R2: walking ones, then scattered gain codes
    for (int i = 0; i < 40; i++)
      wr("R4", 3'd0, 13'((i < 10) ? (1 << i) : ((i * 97 + 13) % 1024)));
    wr("R9", 3'd0, 13'(exp_v[28:19])); // same value: no strobe
    // R5
    for (int i = 0; i < 32; i++) wr("R5", 3'd1, {4'd0, 2'((i / 4) % 4), 2'(i % 4), 5'(i)});
    // R7
    for (int i = 0; i < 16; i++) wr("R7", 3'd3, 13'(i));
    // R6 with run held low: no calibration window
    busy_cnt = 0;
    for (int i = 0; i < 32; i++) wr("R6", 3'd2, 13'(i << 1));
    chk("R6", "busy while run low", 32'(busy_cnt), 32'd0);
    // R8
    for (int a = 4; a < 8; a++) wr("R8", 3'(a), 13'h1fff);
    // R3: 15 and 17 edges discarded
    send({13'h2aa, 3'd0}, 15);
    chk("R3", "15-edge transfer", 32'(obs), 32'(exp_v));
    send({13'h155, 3'd0}, 17);
    chk("R3", "17-edge transfer", 32'(obs), 32'(exp_v));
    // R12: clocking with select high
    for (int i = 0; i < 20; i++) begin
      ser_sdi = i[0];
      repeat (HALF) @(negedge clk) ser_sck = 1'b1;
      repeat (HALF) @(negedge clk) ser_sck = 1'b0;
    end
    repeat (10) @(negedge clk);
    chk("R12", "sck with select high", 32'(obs), 32'(exp_v));

    // R10/R11: full window with a repeated run write inside it
    busy_cnt = 0;
    wr("R10", 3'd2, 13'd1);
    chk("R10", "busy after run release", {31'd0, cal_busy}, 32'd1);
    repeat (5000) @(negedge clk);
    wr("R11", 3'd2, 13'd1);
    for (int g = 0; g < 50000 && cal_busy; g++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R10", "busy window length", 32'(busy_cnt), 32'(CAL_N));
    chk("R10", "busy low after window", {31'd0, cal_busy}, 32'd0);

    // R11: abort
    wr("R11", 3'd2, 13'd0);
    busy_cnt = 0;
    wr("R11", 3'd2, 13'd1);
    repeat (100) @(negedge clk);
    wr("R11", 3'd2, 13'd0);
    chk("R11", "busy after abort", {31'd0, cal_busy}, 32'd0);
    repeat (200) @(negedge clk);
    chk("R11", "busy stays low", {31'd0, cal_busy}, 32'd0);
    chk("R11", "aborted window short", 32'(busy_cnt < CAL_N && busy_cnt > 0), 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule